// File: doc/BRIEF.md
# Bus Voltage Window Fault Supervisor

This block supervises the rectified bus of a power-factor-correction stage from digitised voltage codes. Each new code arrives with a one-cycle valid strobe. On that strobe the block compares the code against three levels: an open-loop floor, a release level and a trip ceiling. It holds the three results until the next strobe. From these held results it filters open-loop and overvoltage events, each with its own debounce length, and drives the enable for the correction stage's gate.

After reset the bus counts as unvalidated, and the gate stays off. A continuous stay inside the corridor between the floor and the release level marks the bus valid. Before that point an overvoltage trips at the release level. After it, overvoltage trips only above the ceiling. A tripped gate comes back on only when the bus is again inside the corridor, which gives hysteresis between the release level and the ceiling.

In run mode, an overvoltage that lasts very long raises a sticky power-down request, which also stands for shutting off the inverter. An overvoltage that coincides with a high low-side current-sense comparison raises a surge flag. The power-down acknowledge input returns the block to its start-up state.

Top module: `bus_window_supervisor`

## Requirements
- R1: After a synchronous reset, or a cycle with `pd_ack` high, `pfc_en`, `bus_valid`, `ol_flt`, `ov_flt`, `surge_flt` and `pd_req` are all 0, and the held sample counts as below the open-loop floor.
- R2: The three comparisons (`sample < TH_LOW`, `sample > TH_REL`, `sample > TH_OV`) are taken only in cycles where `sample_vld` is 1 and are held unchanged otherwise; a changed `sample` without a strobe has no effect on any output.
- R3: `bus_valid` becomes 1 once the held sample has been inside the corridor (not below `TH_LOW` and not above `TH_REL`) on `VALID_CYC` consecutive clock edges, and it stays 1 until reset or `pd_ack`.
- R4: With `op_phase` in 3..8, a held sample below `TH_LOW` on `OL_CYC` consecutive edges sets `ol_flt`.
- R5: With `op_phase` in 3..8, `ov_flt` is set after `OV_CYC` consecutive edges of a held sample above `TH_REL` while `bus_valid` is 0, or above `TH_OV` while `bus_valid` is 1.
- R6: While `op_phase` is outside 3..8, neither `ol_flt` nor `ov_flt` can be set.
- R7: `ol_flt` and `ov_flt` clear on the first edge at which the held sample is inside the corridor; a sample between `TH_REL` and `TH_OV` keeps `ov_flt` set. `pfc_en` is 1 exactly when `bus_valid` is 1 and `ol_flt`, `ov_flt` and `pd_req` are all 0.
- R8: With `op_phase` equal to 8 (run), a held sample above `TH_OV` on `PD_CYC` consecutive edges sets `pd_req`. `pd_req` then stays set until reset or `pd_ack`.
- R9: `surge_flt` is 1 while a held sample above `TH_OV` has coincided on `SURGE_CYC` consecutive edges with either `cs_hi_cmp` in phase 7 (pre-run) or `cs_lo_cmp` in phase 8 (run). It drops on the edge after that condition fails.
- R10: Every debounce run restarts from zero as soon as its condition is false for one edge, so a condition shorter than its window sets nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all durations count its cycles |
| rst | input | 1 | Synchronous reset, active high |
| pd_ack | input | 1 | Power-down acknowledge; restarts the block like a reset |
| op_phase | input | 4 | Operating phase, 1..8; 7 is pre-run, 8 is run |
| sample | input | CODE_W | Bus voltage code |
| sample_vld | input | 1 | Strobe marking a new `sample` |
| cs_hi_cmp | input | 1 | Low-side current sense above the pre-run surge level |
| cs_lo_cmp | input | 1 | Low-side current sense above the run surge level |
| pfc_en | output | 1 | Gate enable for the correction stage |
| bus_valid | output | 1 | Start-up validation complete |
| ol_flt | output | 1 | Open-loop fault, latched |
| ov_flt | output | 1 | Overvoltage fault, latched with hysteresis |
| surge_flt | output | 1 | Surge condition, filtered |
| pd_req | output | 1 | Power-down request, sticky |

## Verification
The bench pushes a code into the hysteresis band between the release level and the ceiling, both before and after validation. A design that used the wrong threshold set would either trip where it should not or clear its overvoltage fault too early. A sample changed without a strobe, and a low pulse one edge shorter than the open-loop window, catch designs that compare raw inputs or fail to restart their counters. The bench also tries a current-sense flag in the wrong phase, and the acknowledge after a run-mode power-down. These expose surge logic that ignores the phase and a power-down request that is not sticky or is never released.

// File: rtl/bus_window_supervisor.sv
module bus_window_supervisor #(
  parameter int CODE_W = 8,
  parameter int CLK_HZ = 10_000_000,
  parameter logic [CODE_W-1:0] TH_LOW = 20,
  parameter logic [CODE_W-1:0] TH_REL = 168,
  parameter logic [CODE_W-1:0] TH_OV  = 174,
  parameter int VALID_CYC = (CLK_HZ / 1_000_000) * 130,
  parameter int OL_CYC    = CLK_HZ / 1_000_000,
  parameter int OV_CYC    = (CLK_HZ / 1_000_000) * 5,
  parameter int PD_CYC    = (CLK_HZ / 1000) * 625,
  parameter int SURGE_CYC = CLK_HZ / 2_000_000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pd_ack,
  input  logic [3:0]        op_phase,
  input  logic [CODE_W-1:0] sample,
  input  logic              sample_vld,
  input  logic              cs_hi_cmp,
  input  logic              cs_lo_cmp,
  output logic              pfc_en,
  output logic              bus_valid,
  output logic              ol_flt,
  output logic              ov_flt,
  output logic              surge_flt,
  output logic              pd_req
);

  localparam int VW = $clog2(VALID_CYC + 1);
  localparam int LW = $clog2(OL_CYC + 1);
  localparam int OW = $clog2(OV_CYC + 1);
  localparam int PW = $clog2(PD_CYC + 1);
  localparam int SW = $clog2(SURGE_CYC + 1);

  logic low_q, rel_q, trip_q;
  logic [VW-1:0] v_cnt;
  logic [LW-1:0] l_cnt;
  logic [OW-1:0] o_cnt;
  logic [PW-1:0] p_cnt;
  logic [SW-1:0] s_cnt;

  wire clr     = rst | pd_ack;
  wire in_corr = !low_q && !rel_q;
  wire ph_act  = (op_phase >= 4'd3) && (op_phase <= 4'd8);
  wire ph_pre  = op_phase == 4'd7;
  wire ph_run  = op_phase == 4'd8;
  wire ol_cond = ph_act && low_q;
  wire ov_cond = ph_act && (bus_valid ? trip_q : rel_q);
  wire pd_cond = ph_run && trip_q;
  wire sg_cond = trip_q && ((ph_pre && cs_hi_cmp) || (ph_run && cs_lo_cmp));

  wire ol_hit = ol_cond && (l_cnt == LW'(OL_CYC - 1));
  wire ov_hit = ov_cond && (o_cnt == OW'(OV_CYC - 1));
  wire pd_hit = pd_cond && (p_cnt == PW'(PD_CYC - 1));
  wire v_hit  = in_corr && (v_cnt == VW'(VALID_CYC - 1));

  always_ff @(posedge clk) begin
    if (clr) begin
      low_q  <= 1'b1;
      rel_q  <= 1'b0;
      trip_q <= 1'b0;
    end else if (sample_vld) begin
      low_q  <= sample < TH_LOW;
      rel_q  <= sample > TH_REL;
      trip_q <= sample > TH_OV;
    end
  end

  always_ff @(posedge clk) begin
    if (clr || !in_corr)                v_cnt <= '0;
    else if (v_cnt != VW'(VALID_CYC))   v_cnt <= v_cnt + 1'b1;
    if (clr || !ol_cond)                l_cnt <= '0;
    else if (l_cnt != LW'(OL_CYC))      l_cnt <= l_cnt + 1'b1;
    if (clr || !ov_cond)                o_cnt <= '0;
    else if (o_cnt != OW'(OV_CYC))      o_cnt <= o_cnt + 1'b1;
    if (clr || !pd_cond)                p_cnt <= '0;
    else if (p_cnt != PW'(PD_CYC))      p_cnt <= p_cnt + 1'b1;
    if (clr || !sg_cond)                s_cnt <= '0;
    else if (s_cnt != SW'(SURGE_CYC))   s_cnt <= s_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      bus_valid <= 1'b0;
      ol_flt    <= 1'b0;
      ov_flt    <= 1'b0;
      pd_req    <= 1'b0;
    end else begin
      if (v_hit)        bus_valid <= 1'b1;
      if (ol_hit)       ol_flt <= 1'b1;
      else if (in_corr) ol_flt <= 1'b0;
      if (ov_hit)       ov_flt <= 1'b1;
      else if (in_corr) ov_flt <= 1'b0;
      if (pd_hit)       pd_req <= 1'b1;
    end
  end

  assign surge_flt = s_cnt == SW'(SURGE_CYC);
  assign pfc_en    = bus_valid && !ol_flt && !ov_flt && !pd_req;

  assert_restart_state_R1: assert property (@(posedge clk) disable iff (rst)
    pd_ack |=> !pfc_en && !bus_valid && !pd_req && !ol_flt && !ov_flt);

  assert_held_compare_R2: assert property (@(posedge clk) disable iff (rst)
    (!sample_vld && !pd_ack) |=> $stable(low_q) && $stable(rel_q) && $stable(trip_q));

  assert_ol_cause_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(ol_flt) |-> $past(low_q));

  assert_phase_gate_R6: assert property (@(posedge clk) disable iff (rst)
    ($rose(ol_flt) || $rose(ov_flt)) |-> $past(ph_act));

  assert_ov_release_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(ov_flt) |-> ($past(!rel_q && !low_q) || $past(pd_ack)));

  assert_pd_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (pd_req && !pd_ack) |=> pd_req);

endmodule

// File: tb/test_bus_window_supervisor.sv
`timescale 1ns/1ps
module test_bus_window_supervisor;
  localparam int VC = 20, OLC = 3, OVC = 6, PDC = 40, SGC = 4;
  localparam int TL = 20, TR = 168, TO = 174;

  logic clk = 0, rst = 1, pd_ack = 0, vld = 0, cs_hi = 0, cs_lo = 0;
  logic [3:0] phase = 4'd1;
  logic [7:0] smp = 8'd0;
  logic pfc_en, bus_valid, ol_flt, ov_flt, surge_flt, pd_req;
  int checks = 0, errors = 0, cyc = 0;

  bus_window_supervisor #(.CODE_W(8), .TH_LOW(8'(TL)), .TH_REL(8'(TR)), .TH_OV(8'(TO)),
    .VALID_CYC(VC), .OL_CYC(OLC), .OV_CYC(OVC), .PD_CYC(PDC), .SURGE_CYC(SGC))
  i_bus_window_supervisor (.clk(clk), .rst(rst), .pd_ack(pd_ack), .op_phase(phase),
    .sample(smp), .sample_vld(vld), .cs_hi_cmp(cs_hi), .cs_lo_cmp(cs_lo),
    .pfc_en(pfc_en), .bus_valid(bus_valid), .ol_flt(ol_flt), .ov_flt(ov_flt),
    .surge_flt(surge_flt), .pd_req(pd_req));

  always #2.5 clk = ~clk;

  // behavioural reference: run lengths of each condition
  bit m_low = 1, m_rel = 0, m_trip = 0, m_valid = 0, m_olf = 0, m_ovf = 0, m_pd = 0;
  int r_corr = 0, r_ol = 0, r_ov = 0, r_pd = 0, r_sg = 0;
  bit corr, act, olc, ovc, pdc, sgc;

  always @(posedge clk) begin
    if (rst || pd_ack) begin
      m_low = 1; m_rel = 0; m_trip = 0; m_valid = 0; m_olf = 0; m_ovf = 0; m_pd = 0;
      r_corr = 0; r_ol = 0; r_ov = 0; r_pd = 0; r_sg = 0;
    end else begin
      corr = !m_low && !m_rel;
      act  = phase >= 3 && phase <= 8;
      olc  = act && m_low;
      ovc  = act && (m_valid ? m_trip : m_rel);
      pdc  = phase == 8 && m_trip;
      sgc  = m_trip && ((phase == 7 && cs_hi) || (phase == 8 && cs_lo));
      r_corr = corr ? r_corr + 1 : 0;
      r_ol = olc ? r_ol + 1 : 0;
      r_ov = ovc ? r_ov + 1 : 0;
      r_pd = pdc ? r_pd + 1 : 0;
      r_sg = sgc ? r_sg + 1 : 0;
      if (r_ol >= OLC) m_olf = 1; else if (corr) m_olf = 0;
      if (r_ov >= OVC) m_ovf = 1; else if (corr) m_ovf = 0;
      if (r_pd >= PDC) m_pd = 1;
      if (r_corr >= VC) m_valid = 1;
      if (vld) begin
        m_low = smp < TL; m_rel = smp > TR; m_trip = smp > TO;
      end
    end
  end

  task automatic chk(input string tag, input logic act_v, input logic exp_v);
    checks++;
    if (act_v !== exp_v) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b at cycle %0d", tag, act_v, exp_v, cyc);
    end
  endtask

  always @(negedge clk) if (cyc > 1) begin
    chk("R3 bus_valid", bus_valid, m_valid);
    chk("R4 ol_flt", ol_flt, m_olf);
    chk("R5 ov_flt", ov_flt, m_ovf);
    chk("R7 pfc_en", pfc_en, m_valid && !m_olf && !m_ovf && !m_pd);
    chk("R8 pd_req", pd_req, m_pd);
    chk("R9 surge_flt", surge_flt, r_sg >= SGC);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      checks++; errors++;
      $display("FAIL watchdog R1..all actual=%0d cycles expected<20000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic drive(input int s);
    @(negedge clk); smp = 8'(s); vld = 1;
    @(negedge clk); vld = 0;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    wait_n(4);
    chk("R1 reset pfc_en", pfc_en, 0);
    chk("R1 reset bus_valid", bus_valid, 0);
    chk("R1 reset pd_req", pd_req, 0);
    rst = 0; phase = 4'd2;
    drive(100); wait_n(VC + 4);
    chk("R3 validated", bus_valid, 1);
    chk("R3 gate on", pfc_en, 1);
    drive(5); wait_n(10);
    chk("R6 no open-loop outside 3..8", ol_flt, 0);
    drive(100); wait_n(2);
    phase = 4'd4; smp = 8'd5; wait_n(10);
    chk("R2 no strobe no effect", ol_flt, 0);
    chk("R2 gate still on", pfc_en, 1);
    drive(5); wait_n(OLC + 3);
    chk("R4 open-loop set", ol_flt, 1);
    chk("R4 gate off", pfc_en, 0);
    drive(100); wait_n(3);
    chk("R7 open-loop release", ol_flt, 0);
    drive(5); drive(100); wait_n(3);
    chk("R10 short low pulse ignored", ol_flt, 0);
    drive(171); wait_n(10);
    chk("R5 validated band no trip", ov_flt, 0);
    drive(180); wait_n(OVC + 3);
    chk("R5 overvoltage set", ov_flt, 1);
    drive(171); wait_n(5);
    chk("R7 hysteresis holds", ov_flt, 1);
    drive(150); wait_n(3);
    chk("R7 overvoltage release", ov_flt, 0);
    phase = 4'd7; cs_lo = 1; drive(180); wait_n(8);
    chk("R9 run flag ignored in pre-run", surge_flt, 0);
    cs_hi = 1; wait_n(SGC + 2);
    chk("R9 pre-run surge", surge_flt, 1);
    cs_hi = 0; wait_n(2);
    chk("R9 surge drops", surge_flt, 0);
    phase = 4'd8; wait_n(SGC + 2);
    chk("R9 run surge", surge_flt, 1);
    wait_n(PDC + 5);
    chk("R8 power-down request", pd_req, 1);
    chk("R8 gate off", pfc_en, 0);
    cs_lo = 0; drive(100); wait_n(5);
    chk("R8 request sticky", pd_req, 1);
    @(negedge clk); pd_ack = 1; @(negedge clk); pd_ack = 0; wait_n(1);
    chk("R1 ack pd_req", pd_req, 0);
    chk("R1 ack bus_valid", bus_valid, 0);
    chk("R1 ack pfc_en", pfc_en, 0);
    phase = 4'd4; drive(171); wait_n(OVC + 3);
    chk("R5 pre-validation trip at release level", ov_flt, 1);
    drive(100); wait_n(3);
    chk("R7 pre-validation release", ov_flt, 0);
    wait_n(VC + 3);
    chk("R3 revalidated", bus_valid, 1);
    chk("R7 gate back on", pfc_en, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule